// File: doc/BRIEF.md
# Panel Indicator and I/O Check Unit

This block holds four indicator lamps for the operator panel and one I/O check trigger. The instruction decoder presents one operation per strobe. Each operation has a two-bit class and a 15-bit address field. A write to the lamp window either lights a single lamp or darkens all four. A lamp test reads one lamp. A check test reads the I/O check trigger.

Both kinds of test consume what they read: a lit lamp is turned off, and a set check trigger is cleared. The two tests report through one skip flag but with opposite sense. A lamp test asks the sequencer to skip the next instruction when the lamp was lit. A check test asks for a skip when the trigger was clear.

The skip flag is combinational and valid in the cycle of the strobe. All state changes take effect at the clock edge that ends that cycle. An external one-cycle pulse sets the check trigger at any time. When that pulse meets a check test in the same cycle, the pulse takes priority.

Top module: `panel_indicator_unit`

## Requirements
- R1: After reset all four lamps are dark and the check trigger is clear, so the first check test requests a skip.
- R2: With class 2'b01 (lamp write) and address octal 141, 142, 143 or 144, lamp bit 0, 1, 2 or 3 of `lamps` is lit after the edge. The other lamps keep their value.
- R3: With class 2'b01 and address octal 140, all four lamps are dark after the edge.
- R4: With class 2'b10 (lamp test) and address octal 141 to 144 naming a lit lamp, `skip_next` is high in the strobe cycle and that lamp is dark after the edge.
- R5: A lamp test naming a dark lamp leaves `skip_next` low and changes no lamp.
- R6: With class 2'b11 (check test) and address octal 5 while the trigger is set, `skip_next` stays low and the trigger is clear after the edge.
- R7: A check test while the trigger is clear drives `skip_next` high.
- R8: A `check_set` pulse sets the trigger. When it coincides with a check test, the test sees the previous value and the trigger is set after the edge.
- R9: `skip_next` is low in every cycle without `op_valid`, and also for class 2'b00 and lamp writes.
- R10: These operations are ignored, with no lamp change, no trigger change and no skip: lamp writes outside octal 140 to 144, lamp tests outside octal 141 to 144, and check tests at any address other than octal 5.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| op_valid | input | 1 | Operation strobe, one cycle per operation |
| op_class | input | 2 | 00 none, 01 lamp write, 10 lamp test, 11 check test |
| op_addr | input | 15 | Address field of the operation |
| check_set | input | 1 | One-cycle pulse that sets the I/O check trigger |
| skip_next | output | 1 | Skip-next-instruction request, valid in the strobe cycle |
| lamps | output | 4 | Lamp states, bit 0 is lamp 1 |

## Verification
The checker watches lamp behaviour on every cycle:
- a lamp write lights the selected lamp;
- the all-dark write darkens every lamp;
- a test of a lit lamp both requests a skip and darkens that lamp;
- a test of a dark lamp requests none;
- writes and idle cycles never raise a skip;
- writes outside the window leave the lamps unchanged.

The check trigger has no output port, so its state is visible only through later check tests. The bench's scenarios cover this indirectly: clear-on-test, the inverted skip sense, and the priority of a set pulse over a coinciding test. The ignored-address cases for tests are also confirmed by a later observation.

// File: rtl/panel_pkg.sv
package panel_pkg;

  typedef enum logic [1:0] {
    OPC_NONE       = 2'b00,
    OPC_LAMP_WRITE = 2'b01,
    OPC_LAMP_TEST  = 2'b10,
    OPC_CHECK_TEST = 2'b11
  } op_class_e;

  // Address of lamp slot i relative to the base of the lamp window.
  function automatic int unsigned lamp_slot_addr(input int unsigned base, input int unsigned slot);
    return base + 1 + slot;
  endfunction

  // Next value of one lamp given its controls; clear-all has priority.
  function automatic logic lamp_next(input logic cur, input logic clr_all,
                                     input logic set, input logic tst);
    if (clr_all)   return 1'b0;
    else if (set)  return 1'b1;
    else if (tst)  return 1'b0;
    else           return cur;
  endfunction

  // Next value of the check trigger; an external set wins over a test.
  function automatic logic check_next(input logic cur, input logic set_pulse, input logic tst);
    if (set_pulse) return 1'b1;
    else if (tst)  return 1'b0;
    else           return cur;
  endfunction

endpackage

// File: rtl/panel_op_decode.sv
module panel_op_decode
  import panel_pkg::*;
#(
  parameter int ADDR_W     = 15,
  parameter int NUM_LAMPS  = 4,
  parameter int LAMP_BASE  = 'o140,
  parameter int CHECK_ADDR = 'o5
) (
  input  logic                 op_valid,
  input  logic [1:0]           op_class,
  input  logic [ADDR_W-1:0]    op_addr,
  output logic [NUM_LAMPS-1:0] lamp_set,
  output logic                 lamp_clear_all,
  output logic [NUM_LAMPS-1:0] lamp_test,
  output logic                 check_test
);

  localparam logic [ADDR_W-1:0] BASE_A  = ADDR_W'(LAMP_BASE);
  localparam logic [ADDR_W-1:0] CHECK_A = ADDR_W'(CHECK_ADDR);

  op_class_e             cls;
  logic                  is_write;
  logic                  is_ltest;
  logic                  is_ctest;
  logic                  base_hit;
  logic [NUM_LAMPS-1:0]  slot_hit;

  assign cls      = op_class_e'(op_class);
  assign is_write = op_valid && (cls == OPC_LAMP_WRITE);
  assign is_ltest = op_valid && (cls == OPC_LAMP_TEST);
  assign is_ctest = op_valid && (cls == OPC_CHECK_TEST);
  assign base_hit = (op_addr == BASE_A);

  for (genvar i = 0; i < NUM_LAMPS; i++) begin : g_slot
    localparam logic [ADDR_W-1:0] SLOT_A = ADDR_W'(lamp_slot_addr(LAMP_BASE, i));
    assign slot_hit[i] = (op_addr == SLOT_A);
  end

  assign lamp_set       = is_write ? slot_hit : '0;
  assign lamp_clear_all = is_write && base_hit;
  assign lamp_test      = is_ltest ? slot_hit : '0;
  assign check_test     = is_ctest && (op_addr == CHECK_A);

endmodule

// File: rtl/panel_lamp_bank.sv
module panel_lamp_bank
  import panel_pkg::*;
#(
  parameter int NUM_LAMPS = 4
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic [NUM_LAMPS-1:0] lamp_set,
  input  logic                 lamp_clear_all,
  input  logic [NUM_LAMPS-1:0] lamp_test,
  output logic [NUM_LAMPS-1:0] lamp_q,
  output logic [NUM_LAMPS-1:0] lamp_hit
);

  for (genvar i = 0; i < NUM_LAMPS; i++) begin : g_lamp
    always_ff @(posedge clk) begin
      if (!rst_n) lamp_q[i] <= 1'b0;
      else        lamp_q[i] <= lamp_next(lamp_q[i], lamp_clear_all, lamp_set[i], lamp_test[i]);
    end
    assign lamp_hit[i] = lamp_test[i] & lamp_q[i];
  end

endmodule

// File: rtl/panel_check_trigger.sv
module panel_check_trigger
  import panel_pkg::*;
(
  input  logic clk,
  input  logic rst_n,
  input  logic check_set,
  input  logic check_test,
  output logic check_q,
  output logic check_skip
);

  always_ff @(posedge clk) begin
    if (!rst_n) check_q <= 1'b0;
    else        check_q <= check_next(check_q, check_set, check_test);
  end

  // Inverted sense: a clear trigger asks for the skip.
  assign check_skip = check_test & ~check_q;

endmodule

// File: rtl/panel_indicator_unit.sv
module panel_indicator_unit #(
  parameter int ADDR_W     = 15,
  parameter int NUM_LAMPS  = 4,
  parameter int LAMP_BASE  = 'o140,
  parameter int CHECK_ADDR = 'o5
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic                 op_valid,
  input  logic [1:0]           op_class,
  input  logic [ADDR_W-1:0]    op_addr,
  input  logic                 check_set,
  output logic                 skip_next,
  output logic [NUM_LAMPS-1:0] lamps
);

  logic [NUM_LAMPS-1:0] lamp_set;
  logic                 lamp_clear_all;
  logic [NUM_LAMPS-1:0] lamp_test;
  logic                 check_test;
  logic [NUM_LAMPS-1:0] lamp_hit;
  logic                 check_q;
  logic                 check_skip;

  panel_op_decode #(
    .ADDR_W(ADDR_W), .NUM_LAMPS(NUM_LAMPS),
    .LAMP_BASE(LAMP_BASE), .CHECK_ADDR(CHECK_ADDR)
  ) u_decode (
    .op_valid       (op_valid),
    .op_class       (op_class),
    .op_addr        (op_addr),
    .lamp_set       (lamp_set),
    .lamp_clear_all (lamp_clear_all),
    .lamp_test      (lamp_test),
    .check_test     (check_test)
  );

  panel_lamp_bank #(.NUM_LAMPS(NUM_LAMPS)) u_lamps (
    .clk            (clk),
    .rst_n          (rst_n),
    .lamp_set       (lamp_set),
    .lamp_clear_all (lamp_clear_all),
    .lamp_test      (lamp_test),
    .lamp_q         (lamps),
    .lamp_hit       (lamp_hit)
  );

  panel_check_trigger u_check (
    .clk        (clk),
    .rst_n      (rst_n),
    .check_set  (check_set),
    .check_test (check_test),
    .check_q    (check_q),
    .check_skip (check_skip)
  );

  assign skip_next = (|lamp_hit) | check_skip;

endmodule

// File: rtl/panel_indicator_unit_sva.sv
module panel_indicator_unit_sva #(
  parameter int ADDR_W    = 15,
  parameter int NUM_LAMPS = 4,
  parameter int LAMP_BASE = 'o140
) (
  input logic                 clk,
  input logic                 rst_n,
  input logic                 op_valid,
  input logic [1:0]           op_class,
  input logic [ADDR_W-1:0]    op_addr,
  input logic                 skip_next,
  input logic [NUM_LAMPS-1:0] lamps,
  input logic [NUM_LAMPS-1:0] lamp_set,
  input logic                 lamp_clear_all,
  input logic [NUM_LAMPS-1:0] lamp_test
);

  localparam logic [ADDR_W-1:0] LO_A = ADDR_W'(LAMP_BASE);
  localparam logic [ADDR_W-1:0] HI_A = ADDR_W'(LAMP_BASE + NUM_LAMPS);

  assert_set_lights_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (lamp_set != '0) |=> ((lamps & $past(lamp_set)) == $past(lamp_set)));

  assert_single_select_R2: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(lamp_set) && $onehot0(lamp_test));

  assert_clear_all_R3: assert property (@(posedge clk) disable iff (!rst_n)
    lamp_clear_all |=> (lamps == '0));

  assert_lit_test_skips_R4: assert property (@(posedge clk) disable iff (!rst_n)
    ((lamp_test & lamps) != '0) |-> skip_next);

  assert_test_darkens_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (lamp_test != '0) |=> ((lamps & $past(lamp_test)) == '0));

  assert_dark_test_noskip_R5: assert property (@(posedge clk) disable iff (!rst_n)
    ((lamp_test != '0) && ((lamp_test & lamps) == '0)) |-> !skip_next);

  assert_no_strobe_noskip_R9: assert property (@(posedge clk) disable iff (!rst_n)
    !op_valid |-> !skip_next);

  assert_write_noskip_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (op_valid && (op_class == 2'b01 || op_class == 2'b00)) |-> !skip_next);

  assert_outside_write_ignored_R10: assert property (@(posedge clk) disable iff (!rst_n)
    (op_valid && op_class == 2'b01 && (op_addr < LO_A || op_addr > HI_A)) |=> $stable(lamps));

endmodule

bind panel_indicator_unit panel_indicator_unit_sva #(
  .ADDR_W(ADDR_W), .NUM_LAMPS(NUM_LAMPS), .LAMP_BASE(LAMP_BASE)
) u_sva (
  .clk            (clk),
  .rst_n          (rst_n),
  .op_valid       (op_valid),
  .op_class       (op_class),
  .op_addr        (op_addr),
  .skip_next      (skip_next),
  .lamps          (lamps),
  .lamp_set       (lamp_set),
  .lamp_clear_all (lamp_clear_all),
  .lamp_test      (lamp_test)
);

// File: tb/panel_indicator_unit_test.sv
`timescale 1ns/1ps
module panel_indicator_unit_test;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        op_valid = 1'b0;
  logic [1:0]  op_class = 2'b00;
  logic [14:0] op_addr = '0;
  logic        check_set = 1'b0;
  logic        skip_next;
  logic [3:0]  lamps;

  int checks = 0;
  int errors = 0;
  bit done = 0;

  // bench model state
  logic [3:0] m_lamps = '0;
  logic       m_chk = 1'b0;

  always #4 clk = ~clk;

  panel_indicator_unit uut (
    .clk(clk), .rst_n(rst_n), .op_valid(op_valid), .op_class(op_class),
    .op_addr(op_addr), .check_set(check_set), .skip_next(skip_next), .lamps(lamps)
  );

  task automatic check_eq(input string tag, input int act, input int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  // One strobed operation; checks skip in the strobe cycle and lamps after it.
  task automatic run_op(input logic [1:0] cls, input logic [14:0] addr,
                        input logic pulse, input string tag);
    logic       exp_skip;
    logic [3:0] nl;
    logic       nc;
    exp_skip = 1'b0;
    nl = m_lamps;
    nc = m_chk;
    case (cls)
      2'b01: begin
        if (addr == 15'o140) nl = 4'b0000;
        else if (addr >= 15'o141 && addr <= 15'o144) nl[addr - 15'o141] = 1'b1;
      end
      2'b10: begin
        if (addr >= 15'o141 && addr <= 15'o144 && m_lamps[addr - 15'o141]) begin
          exp_skip = 1'b1;
          nl[addr - 15'o141] = 1'b0;
        end
      end
      2'b11: begin
        if (addr == 15'o5) begin
          if (m_chk) nc = 1'b0;
          else       exp_skip = 1'b1;
        end
      end
      default: ;
    endcase
    if (pulse) nc = 1'b1;
    @(negedge clk);
    op_valid = 1'b1; op_class = cls; op_addr = addr; check_set = pulse;
    #1;
    check_eq({tag, " skip"}, int'(skip_next), int'(exp_skip));
    @(negedge clk);
    op_valid = 1'b0; op_class = 2'b00; op_addr = '0; check_set = 1'b0;
    check_eq({tag, " lamps"}, int'(lamps), int'(nl));
    m_lamps = nl;
    m_chk = nc;
  endtask

  task automatic t_reset;
    @(negedge clk); rst_n = 1'b0;
    repeat (2) @(negedge clk);
    rst_n = 1'b1;
    m_lamps = '0; m_chk = 1'b0;
    check_eq("R1 lamps after reset", int'(lamps), 0);
    check_eq("R1 no skip idle", int'(skip_next), 0);
    run_op(2'b11, 15'o5, 1'b0, "R1 R7 first check test skips");
  endtask

  task automatic t_set_each;
    run_op(2'b01, 15'o143, 1'b0, "R2 light lamp 3");
    run_op(2'b01, 15'o141, 1'b0, "R2 light lamp 1");
    run_op(2'b01, 15'o144, 1'b0, "R2 light lamp 4");
    run_op(2'b01, 15'o142, 1'b0, "R2 light lamp 2");
    run_op(2'b01, 15'o142, 1'b0, "R2 relight lamp 2");
    check_eq("R2 all lit", int'(lamps), 4'hF);
  endtask

  task automatic t_clear;
    run_op(2'b01, 15'o140, 1'b0, "R3 darken all");
    check_eq("R3 all dark", int'(lamps), 0);
  endtask

  task automatic t_lamp_tests;
    run_op(2'b01, 15'o142, 1'b0, "R2 prep lamp 2");
    run_op(2'b01, 15'o144, 1'b0, "R2 prep lamp 4");
    run_op(2'b10, 15'o142, 1'b0, "R4 test lit lamp 2");
    run_op(2'b10, 15'o142, 1'b0, "R5 retest now dark lamp 2");
    run_op(2'b10, 15'o141, 1'b0, "R5 test dark lamp 1");
    run_op(2'b10, 15'o144, 1'b0, "R4 test lit lamp 4");
    check_eq("R4 lamps dark after tests", int'(lamps), 0);
  endtask

  task automatic t_check_trigger;
    run_op(2'b00, 15'o0, 1'b1, "R8 set pulse alone");
    run_op(2'b11, 15'o5, 1'b0, "R6 test set trigger");
    run_op(2'b11, 15'o5, 1'b0, "R7 test cleared trigger");
    run_op(2'b11, 15'o5, 1'b1, "R8 set with test, old value clear");
    run_op(2'b11, 15'o5, 1'b0, "R8 trigger set after coincidence");
  endtask

  task automatic t_ignored;
    run_op(2'b01, 15'o141, 1'b0, "R2 prep lamp 1");
    run_op(2'b01, 15'o145, 1'b0, "R10 write above window");
    run_op(2'b01, 15'o137, 1'b0, "R10 write below window");
    run_op(2'b10, 15'o140, 1'b0, "R10 lamp test at base");
    run_op(2'b10, 15'o41, 1'b0, "R10 lamp test other addr");
    run_op(2'b11, 15'o6, 1'b0, "R10 check test wrong addr");
    run_op(2'b11, 15'o5, 1'b0, "R10 trigger untouched, still clear");
    run_op(2'b00, 15'o141, 1'b0, "R9 class none on lit lamp");
    run_op(2'b10, 15'o141, 1'b0, "R10 lamp 1 still lit");
  endtask

  task automatic t_no_strobe;
    run_op(2'b01, 15'o143, 1'b0, "R2 prep lamp 3");
    @(negedge clk);
    op_valid = 1'b0; op_class = 2'b10; op_addr = 15'o143;
    #1;
    check_eq("R9 no strobe no skip", int'(skip_next), 0);
    @(negedge clk);
    op_class = 2'b00; op_addr = '0;
    check_eq("R9 no strobe lamp kept", int'(lamps), 4'b0100);
    run_op(2'b01, 15'o141, 1'b0, "R9 write has no skip");
  endtask

  initial begin
    #(8 * 200000);
    if (!done) begin
      errors++;
      $display("FAIL watchdog expired");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    t_reset();
    t_set_each();
    t_clear();
    t_lamp_tests();
    t_check_trigger();
    t_ignored();
    t_no_strobe();
    t_reset();
    done = 1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

endmodule